// File: doc/BRIEF.md
# Hex Record Stream Decoder

This block sits behind a character receiver and turns a stream of ASCII text in the common hexadecimal record format into memory writes. One character is offered per cycle on a valid strobe. Text between records is thrown away until a colon appears. After the colon, the block reads pairs of hex digits and turns each pair into a byte. It then walks the record fields: byte count, address high, address low, record type, the data bytes and a checksum.

Each data byte leaves the block as a single-cycle write with a 16-bit address and an 8-bit value. The address is the record's own address, shifted up by a fixed amount added to its high byte. That amount is the parameter `BASE_HI`. At the close of each record the block gives a one-cycle verdict.

A failed checksum sets a sticky flag, and parsing moves on to the next record. An end-of-file record with a good checksum raises a level flag. Both flags are cleared by a start-of-download pulse, which also abandons any record that is half read.

Top module: `hexrec_parser`

## Requirements
- R1: While hunting for a record, every character other than a colon (0x3A) is discarded, with no write and no pulse on `rec_pass_o`, `rec_fail_o` or `rec_err_o`. A cycle without `char_valid_i` produces none of these either.
- R2: Inside a record, the characters 0-9, A-F and a-f are accepted as hex digits with values 0 to 15. Any other character, a colon included, pulses `rec_err_o` for one cycle after it is taken and returns the block to hunting, with no pass or fail for that record.
- R3: A record passes when the 8-bit sum of its count, both address bytes, type, every data byte and the checksum is zero. Its pass or fail pulse appears in the cycle after the second checksum digit is taken.
- R4: In a type 0 record, each data byte produces exactly one `wr_valid_o` cycle, in the cycle after its second digit is taken. `wr_data_o` carries the byte value, high digit first. A count of zero produces no write.
- R5: The first data byte is written at address {(address high + BASE_HI) mod 256, address low}. Each later byte goes to the previous address plus one, carrying across the full 16 bits and wrapping from 0xFFFF to 0x0000.
- R6: A type 1 record reads its checksum right after the type byte. With a good checksum it pulses `rec_pass_o` and sets `eof_o`, which stays high until a start pulse. With a bad checksum it pulses `rec_fail_o` and leaves `eof_o` unchanged.
- R7: A type 2 record produces no write and no pulse. Its remaining characters are discarded until the next colon.
- R8: Any record type other than 0, 1 or 2 pulses `rec_err_o` in the cycle after the type byte completes, writes nothing and returns the block to hunting.
- R9: A checksum failure pulses `rec_fail_o` and sets `fail_sticky_o`. Data bytes already written stay written, and the next record is parsed normally.
- R10: A cycle with `start_i` high clears `fail_sticky_o` and `eof_o` and returns the block to hunting. Any character offered in that same cycle is ignored.
- R11: After reset, all outputs are low and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start of download: clears the flags and aborts the current record |
| char_valid_i | input | 1 | `char_i` holds a character this cycle |
| char_i | input | 8 | ASCII character |
| wr_valid_o | output | 1 | One-cycle write strobe for a data byte |
| wr_addr_o | output | 16 | Write address (record address plus the offset) |
| wr_data_o | output | 8 | Write data byte |
| rec_pass_o | output | 1 | One-cycle pulse: record checksum correct |
| rec_fail_o | output | 1 | One-cycle pulse: record checksum wrong |
| rec_err_o | output | 1 | One-cycle pulse: bad character or unknown record type |
| eof_o | output | 1 | End-of-file record accepted |
| fail_sticky_o | output | 1 | At least one checksum failure since the last start |

## Verification
The bench builds the block with `BASE_HI` = 0x10. With that value, a high address byte of 0xF0 or above wraps, and a low byte near 0xFF carries into the high byte, so the carry and wrap paths of the address are reachable with short records.

Because characters, types and checksums are all 8 bits wide, the bench sweeps each of them through all 256 values. It offers every character both while hunting and as the first digit inside a record. It sends a record of every type. It sends one record with each possible checksum error. Every expected address, byte and verdict is computed from the record fields in the bench.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int ADDR_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CH_MARK   = 8'h3A;
    localparam logic [BYTE_W-1:0] TYP_DATA  = 8'h00;
    localparam logic [BYTE_W-1:0] TYP_EOF   = 8'h01;
    localparam logic [BYTE_W-1:0] TYP_SKIP  = 8'h02;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_AHI,
        ST_ALO,
        ST_TYPE,
        ST_DATA,
        ST_CSUM
    } prs_state_e;

    typedef struct packed {
        prs_state_e          st;
        logic [BYTE_W-1:0]   left;
        logic [BYTE_W-1:0]   rtype;
        logic [BYTE_W-1:0]   ahi;
        logic [ADDR_W-1:0]   addr;
        logic                wr_vld;
        logic [ADDR_W-1:0]   wr_addr;
        logic [BYTE_W-1:0]   wr_data;
        logic                pass;
        logic                fail;
        logic                err;
        logic                eof;
        logic                sticky;
    } prs_regs_t;

endpackage

// File: rtl/hexrec_nibble.sv
module hexrec_nibble
    import hexrec_pkg::*;
(
    input  logic [BYTE_W-1:0] ch_i,
    output logic              is_hex_o,
    output logic [NIB_W-1:0]  val_o
);

    always_comb begin
        is_hex_o = 1'b1;
        val_o    = '0;
        if (ch_i >= 8'h30 && ch_i <= 8'h39) begin
            val_o = ch_i[NIB_W-1:0];
        end else if ((ch_i >= 8'h41 && ch_i <= 8'h46) ||
                     (ch_i >= 8'h61 && ch_i <= 8'h66)) begin
            // letters: low nibble 1..6 maps to 10..15
            val_o = ch_i[NIB_W-1:0] + 4'd9;
        end else begin
            is_hex_o = 1'b0;
        end
    end

endmodule

// File: rtl/hexrec_pair.sv
module hexrec_pair
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              nib_vld_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o
);

    typedef struct packed {
        logic             half;
        logic [NIB_W-1:0] hi;
    } pair_t;

    pair_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        byte_vld_o = nib_vld_i && r_q.half && !clr_i;
        byte_o     = {r_q.hi, nib_i};
        if (clr_i) begin
            r_d.half = 1'b0;
        end else if (nib_vld_i) begin
            r_d.half = !r_q.half;
            if (!r_q.half) begin
                r_d.hi = nib_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/hexrec_csum.sv
module hexrec_csum
    import hexrec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              add_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              zero_o
);

    logic [BYTE_W-1:0] sum_d, sum_q;
    logic [BYTE_W-1:0] sum_inc;

    always_comb begin
        sum_inc = sum_q + byte_i;
        zero_o  = (sum_inc == '0);
        sum_d   = sum_q;
        if (clr_i) begin
            sum_d = '0;
        end else if (add_i) begin
            sum_d = sum_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_d;
        end
    end

endmodule

// File: rtl/hexrec_parser.sv
module hexrec_parser
    import hexrec_pkg::*;
#(
    parameter logic [7:0] BASE_HI = 8'h10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        char_valid_i,
    input  logic [7:0]  char_i,
    output logic        wr_valid_o,
    output logic [15:0] wr_addr_o,
    output logic [7:0]  wr_data_o,
    output logic        rec_pass_o,
    output logic        rec_fail_o,
    output logic        rec_err_o,
    output logic        eof_o,
    output logic        fail_sticky_o
);

    prs_regs_t r_d, r_q;

    logic              is_hex;
    logic [NIB_W-1:0]  nib_val;
    logic              in_rec;
    logic              hex_take;
    logic              bad_take;
    logic              mark_take;
    logic              seq_clr;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic              sum_zero;

    hexrec_nibble u_nib (
        .ch_i     (char_i),
        .is_hex_o (is_hex),
        .val_o    (nib_val)
    );

    always_comb begin
        in_rec    = (r_q.st != ST_HUNT);
        hex_take  = char_valid_i && is_hex && in_rec;
        bad_take  = char_valid_i && !is_hex && in_rec;
        mark_take = char_valid_i && (char_i == CH_MARK) && !in_rec;
        seq_clr   = start_i || !in_rec || bad_take;
    end

    hexrec_pair u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (seq_clr),
        .nib_vld_i  (hex_take),
        .nib_i      (nib_val),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val)
    );

    hexrec_csum u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (seq_clr),
        .add_i  (byte_vld),
        .byte_i (byte_val),
        .zero_o (sum_zero)
    );

    always_comb begin
        r_d        = r_q;
        r_d.wr_vld = 1'b0;
        r_d.pass   = 1'b0;
        r_d.fail   = 1'b0;
        r_d.err    = 1'b0;

        if (start_i) begin
            r_d.st     = ST_HUNT;
            r_d.sticky = 1'b0;
            r_d.eof    = 1'b0;
        end else if (r_q.st == ST_HUNT) begin
            if (mark_take) begin
                r_d.st = ST_LEN;
            end
        end else if (bad_take) begin
            r_d.err = 1'b1;
            r_d.st  = ST_HUNT;
        end else if (byte_vld) begin
            unique case (r_q.st)
                ST_LEN: begin
                    r_d.left = byte_val;
                    r_d.st   = ST_AHI;
                end
                ST_AHI: begin
                    r_d.ahi = byte_val;
                    r_d.st  = ST_ALO;
                end
                ST_ALO: begin
                    r_d.addr = {r_q.ahi + BASE_HI, byte_val};
                    r_d.st   = ST_TYPE;
                end
                ST_TYPE: begin
                    r_d.rtype = byte_val;
                    if (byte_val == TYP_DATA) begin
                        r_d.st = (r_q.left == '0) ? ST_CSUM : ST_DATA;
                    end else if (byte_val == TYP_EOF) begin
                        r_d.st = ST_CSUM;
                    end else if (byte_val == TYP_SKIP) begin
                        r_d.st = ST_HUNT;
                    end else begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HUNT;
                    end
                end
                ST_DATA: begin
                    r_d.wr_vld  = 1'b1;
                    r_d.wr_addr = r_q.addr;
                    r_d.wr_data = byte_val;
                    r_d.addr    = r_q.addr + 16'd1;
                    r_d.left    = r_q.left - 8'd1;
                    if (r_q.left == 8'd1) begin
                        r_d.st = ST_CSUM;
                    end
                end
                ST_CSUM: begin
                    if (sum_zero) begin
                        r_d.pass = 1'b1;
                        if (r_q.rtype == TYP_EOF) begin
                            r_d.eof = 1'b1;
                        end
                    end else begin
                        r_d.fail   = 1'b1;
                        r_d.sticky = 1'b1;
                    end
                    r_d.st = ST_HUNT;
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_valid_o    = r_q.wr_vld;
    assign wr_addr_o     = r_q.wr_addr;
    assign wr_data_o     = r_q.wr_data;
    assign rec_pass_o    = r_q.pass;
    assign rec_fail_o    = r_q.fail;
    assign rec_err_o     = r_q.err;
    assign eof_o         = r_q.eof;
    assign fail_sticky_o = r_q.sticky;

endmodule

// File: rtl/hexrec_parser_chk.sv
module hexrec_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        char_valid_i,
    input logic        wr_valid_o,
    input logic        rec_pass_o,
    input logic        rec_fail_o,
    input logic        rec_err_o,
    input logic        eof_o,
    input logic        fail_sticky_o
);

    // R3: at most one verdict per cycle
    p_one_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_pass_o, rec_fail_o, rec_err_o}));

    // R1: no character, no activity in the next cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid_i |=> !(wr_valid_o || rec_pass_o || rec_fail_o || rec_err_o));

    // R9: a failure is always reflected in the sticky flag
    p_fail_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_fail_o |-> fail_sticky_o);

    // R10: the sticky flag holds until a start
    p_sticky_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fail_sticky_o && !start_i |=> fail_sticky_o);

    // R6: end-of-file holds until a start
    p_eof_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o && !start_i |=> eof_o);

    // R10: start clears both flags and suppresses all events
    p_start_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !(eof_o || fail_sticky_o || wr_valid_o || rec_pass_o || rec_fail_o || rec_err_o));

endmodule

bind hexrec_parser hexrec_parser_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .char_valid_i  (char_valid_i),
    .wr_valid_o    (wr_valid_o),
    .rec_pass_o    (rec_pass_o),
    .rec_fail_o    (rec_fail_o),
    .rec_err_o     (rec_err_o),
    .eof_o         (eof_o),
    .fail_sticky_o (fail_sticky_o)
);

// File: tb/sim_hexrec_parser.sv
module sim_hexrec_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        char_valid_i = 1'b0;
    logic [7:0]  char_i = 8'h00;
    logic        wr_valid_o;
    logic [15:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic        rec_pass_o, rec_fail_o, rec_err_o, eof_o, fail_sticky_o;

    localparam logic [7:0] BASE = 8'h10;

    hexrec_parser #(.BASE_HI(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .char_valid_i(char_valid_i), .char_i(char_i),
        .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .rec_pass_o(rec_pass_o), .rec_fail_o(rec_fail_o), .rec_err_o(rec_err_o),
        .eof_o(eof_o), .fail_sticky_o(fail_sticky_o)
    );

    always #4 clk = !clk;

    int n_checks = 0;
    int n_fail = 0;
    int n_wr = 0, n_pass = 0, n_rfail = 0, n_err = 0;
    logic [15:0] log_addr [0:15];
    logic [7:0]  log_data [0:15];
    logic [7:0]  dbuf [0:15];
    int cycles = 0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid_o) begin
                if (n_wr < 16) begin
                    log_addr[n_wr] = wr_addr_o;
                    log_data[n_wr] = wr_data_o;
                end
                n_wr++;
            end
            if (rec_pass_o) n_pass++;
            if (rec_fail_o) n_rfail++;
            if (rec_err_o)  n_err++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        check(act == exp, req, what, act, exp);
    endtask

    task automatic clr_log();
        n_wr = 0; n_pass = 0; n_rfail = 0; n_err = 0;
    endtask

    task automatic put_char(input logic [7:0] c);
        @(negedge clk);
        char_i = c;
        char_valid_i = 1'b1;
        @(negedge clk);
        char_valid_i = 1'b0;
        #1;
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 4'd10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    function automatic int nib_of(input int c);
        if (c >= 48 && c <= 57)  return c - 48;
        if (c >= 65 && c <= 70)  return c - 55;
        if (c >= 97 && c <= 102) return c - 87;
        return -1;
    endfunction

    task automatic put_byte(input logic [7:0] b, input bit lower);
        put_char(hexc(b[7:4], lower));
        put_char(hexc(b[3:0], lower));
    endtask

    // sends a whole record; the checksum is the correct one XOR csx
    task automatic send_rec(input logic [7:0] len, input logic [7:0] ahi,
                            input logic [7:0] alo, input logic [7:0] typ,
                            input logic [7:0] csx, input bit lower);
        logic [7:0] s;
        s = len + ahi + alo + typ;
        for (int i = 0; i < int'(len); i++) s = s + dbuf[i];
        put_char(8'h3A);
        put_byte(len, lower);
        put_byte(ahi, lower);
        put_byte(alo, lower);
        put_byte(typ, lower);
        for (int i = 0; i < int'(len); i++) put_byte(dbuf[i], lower);
        put_byte((8'h00 - s) ^ csx, lower);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_fail++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_eq("R11", "outputs at reset",
               int'({wr_valid_o, rec_pass_o, rec_fail_o, rec_err_o, eof_o, fail_sticky_o}), 0);
        rst_n = 1'b1;
        #1;
        clr_log();

        // R1: every non-colon character is discarded while hunting
        for (int c = 0; c < 256; c++) begin
            if (c != 8'h3A) put_char(8'(c));
        end
        chk_eq("R1", "events while hunting", n_wr + n_pass + n_rfail + n_err, 0);

        // R2: every character as the first digit inside a record
        for (int c = 0; c < 256; c++) begin
            do_start();
            clr_log();
            put_char(8'h3A);
            put_char(8'(c));
            chk_eq("R2", $sformatf("error for char %0d", c), n_err, (nib_of(c) < 0) ? 1 : 0);
        end

        // R2/R4: value of each accepted digit, both cases
        for (int c = 0; c < 256; c++) begin
            int v;
            logic [7:0] s;
            v = nib_of(c);
            if (v >= 0) begin
                do_start();
                clr_log();
                s = 8'h01 + 8'(v * 17);
                put_char(8'h3A);
                put_byte(8'h01, 1'b0);
                put_byte(8'h00, 1'b0);
                put_byte(8'h00, 1'b0);
                put_byte(8'h00, 1'b0);
                put_char(8'(c));
                put_char(8'(c));
                put_byte(8'h00 - s, 1'b1);
                chk_eq("R2", $sformatf("digit %0d pass", c), n_pass, 1);
                chk_eq("R4", $sformatf("digit %0d data", c), int'(log_data[0]), v * 17);
            end
        end

        // R2: colon inside a record aborts it; the next record is fine
        do_start();
        clr_log();
        put_char(8'h3A);
        put_char(8'h30);
        put_char(8'h3A);
        chk_eq("R2", "colon inside record err", n_err, 1);
        dbuf[0] = 8'h77;
        send_rec(8'd1, 8'h00, 8'h05, 8'h00, 8'h00, 1'b0);
        chk_eq("R2", "record after abort pass", n_pass, 1);
        chk_eq("R2", "no verdict for aborted", n_rfail, 0);

        // R3/R9: every checksum error value
        do_start();
        for (int x = 0; x < 256; x++) begin
            clr_log();
            dbuf[0] = 8'hA5;
            dbuf[1] = 8'h5A;
            send_rec(8'd2, 8'h12, 8'h34, 8'h00, 8'(x), 1'b0);
            chk_eq("R3", $sformatf("pass csx=%0d", x), n_pass, (x == 0) ? 1 : 0);
            chk_eq("R9", $sformatf("fail csx=%0d", x), n_rfail, (x == 0) ? 0 : 1);
            chk_eq("R9", $sformatf("writes csx=%0d", x), n_wr, 2);
            chk_eq("R9", $sformatf("sticky csx=%0d", x), int'(fail_sticky_o), (x == 0) ? 0 : 1);
        end

        // R5: address offset, carry and wrap
        begin
            logic [7:0] hs [0:4];
            logic [7:0] ls [0:4];
            int ln [0:4];
            hs = '{8'h00, 8'hF0, 8'hEF, 8'h3C, 8'hF5};
            ls = '{8'h00, 8'h10, 8'hFE, 8'hFF, 8'h80};
            ln = '{3, 2, 4, 2, 0};
            for (int k = 0; k < 5; k++) begin
                logic [15:0] base;
                do_start();
                clr_log();
                for (int i = 0; i < ln[k]; i++) dbuf[i] = 8'(i * 37 + k + 1);
                send_rec(8'(ln[k]), hs[k], ls[k], 8'h00, 8'h00, k[0]);
                base = {hs[k] + BASE, ls[k]};
                chk_eq("R4", $sformatf("write count case %0d", k), n_wr, ln[k]);
                chk_eq("R3", $sformatf("pass case %0d", k), n_pass, 1);
                for (int i = 0; i < ln[k]; i++) begin
                    chk_eq("R5", $sformatf("addr case %0d byte %0d", k, i),
                           int'(log_addr[i]), int'(16'(base + 16'(i))));
                    chk_eq("R4", $sformatf("data case %0d byte %0d", k, i),
                           int'(log_data[i]), int'(dbuf[i]));
                end
            end
        end

        // R6/R7/R8: every record type
        for (int t = 0; t < 256; t++) begin
            do_start();
            clr_log();
            send_rec(8'd0, 8'h00, 8'h00, 8'(t), 8'h00, 1'b0);
            chk_eq("R6", $sformatf("pass type %0d", t), n_pass, (t < 2) ? 1 : 0);
            chk_eq("R6", $sformatf("eof type %0d", t), int'(eof_o), (t == 1) ? 1 : 0);
            chk_eq("R8", $sformatf("err type %0d", t), n_err, (t > 2) ? 1 : 0);
            chk_eq("R7", $sformatf("fail type %0d", t), n_rfail, 0);
        end

        // R7: skipped type with a body writes nothing
        do_start();
        clr_log();
        dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33;
        send_rec(8'd3, 8'h00, 8'h00, 8'h02, 8'h00, 1'b0);
        chk_eq("R7", "skip type events", n_wr + n_pass + n_rfail + n_err, 0);

        // R6: bad end-of-file checksum
        do_start();
        clr_log();
        send_rec(8'd0, 8'h00, 8'h00, 8'h01, 8'h01, 1'b0);
        chk_eq("R6", "bad eof fail", n_rfail, 1);
        chk_eq("R6", "bad eof flag", int'(eof_o), 0);
        // R6: eof persists across later records
        send_rec(8'd0, 8'h00, 8'h00, 8'h01, 8'h00, 1'b0);
        dbuf[0] = 8'h01;
        send_rec(8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
        chk_eq("R6", "eof persists", int'(eof_o), 1);

        // R10: start clears flags
        chk_eq("R10", "sticky before start", int'(fail_sticky_o), 1);
        do_start();
        chk_eq("R10", "flags after start", int'({eof_o, fail_sticky_o}), 0);

        // R10: start aborts a partial record
        clr_log();
        put_char(8'h3A);
        put_byte(8'h01, 1'b0);
        do_start();
        put_byte(8'h00, 1'b0);
        put_byte(8'h00, 1'b0);
        put_byte(8'h00, 1'b0);
        put_byte(8'h44, 1'b0);
        put_byte(8'hBB, 1'b0);
        chk_eq("R10", "partial record after start", n_wr + n_pass + n_rfail + n_err, 0);

        // R10: a colon in the start cycle is ignored
        clr_log();
        @(negedge clk);
        start_i = 1'b1;
        char_i = 8'h3A;
        char_valid_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        char_valid_i = 1'b0;
        #1;
        put_byte(8'h00, 1'b0);
        put_byte(8'h00, 1'b0);
        put_byte(8'h00, 1'b0);
        put_byte(8'h01, 1'b0);
        put_byte(8'hFF, 1'b0);
        chk_eq("R10", "colon with start ignored", n_pass + int'(eof_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule